// File: doc/BRIEF.md
# Coprocessor Register Read Responder with Stall Control

This block answers a CPU's requests to copy coprocessor register contents into CPU registers. A request carries an instruction word, a phase code and a flag that picks a single-register or a dual-register read. The block holds a bank of sixteen data registers, which a separate load port fills. It answers each request one cycle later with one of three codes: none, busy or done. A done answer carries one register value, or two values for a dual read.

The answer can be held back in two ways. The first is a programmable wait count: a non-zero count makes an opening request answer busy for that many responses. The second is a deadline on a free-running cycle counter, which an earlier data-processing operation leaves through a write port. While the counter is below the deadline, every request answers busy. When a retry arrives after a stall has run out, it is completed as if it were an opening request. The current counter value is driven on an output, so that a deadline can be set relative to it.

Top module: `cpr_read_unit`

## Requirements
- R1: The response code is 0 for none, 1 for busy and 2 for done. It appears one cycle after the request, and a cycle without a request gives code 0 on the next cycle.
- R2: A single read takes its register index from instruction bits 19:16 and returns that register on data0 with data1 at zero. Whenever the code is not done, both data outputs are zero.
- R3: A dual read returns register idx on data0 and register (idx+1) mod 16 on data1, in the same done response.
- R4: With a wait count N>0, an opening request (phase 0) answers busy. Retries (phase 1) keep answering busy until exactly N busy responses have been given in total. The next retry completes with the data.
- R5: While the cycle counter is below the stored deadline, every request answers busy and no wait-count stall is started.
- R6: A retry (phase 1) that arrives with no stall armed is handled as an opening request. It completes at once when N=0, or it starts the wait-count stall.
- R7: Phases 2 and 3 always answer busy.
- R8: The cycle counter starts at 0 after reset and rises by one each cycle. A deadline written through the write port applies from the next cycle.
- R9: During reset and on the first cycle after it, the response code and both data outputs are zero.
- R10: A write on the bank load port replaces the indexed register, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_we | input | 1 | Bank load strobe |
| bank_waddr | input | 4 | Bank register to load |
| bank_wdata | input | 32 | Value to load |
| dl_we | input | 1 | Deadline write strobe |
| dl_value | input | 32 | Deadline, in cycle-counter units |
| wait_cycles | input | 8 | Busy responses to give per opening request (0 = none) |
| req_valid | input | 1 | A request is present this cycle |
| req_phase | input | 2 | 0 opening, 1 retry, 2/3 other |
| req_dual | input | 1 | 1 = dual-register read |
| req_instr | input | 32 | Instruction word, index in bits 19:16 |
| rsp_code | output | 2 | 0 none, 1 busy, 2 done |
| rsp_data0 | output | 32 | First register value on done |
| rsp_data1 | output | 32 | Second register value on a dual done |
| cycle_now | output | 32 | Free-running cycle counter |

## Verification
Each response is registered, so the bench drives a request on a falling edge and reads the code and data on the next falling edge, one rising edge later. A wait count of N is checked by counting busy responses across consecutive retries; the count must equal N, and the following retry must bring the data. For deadlines, the bench reads the cycle counter in cycle c and writes the deadline c+1+D. The deadline lands on the next rising edge, where the counter becomes c+1, so exactly D requests issued back to back from that cycle must answer busy.

// File: rtl/cpr_pkg.sv
// Shared encodings for the coprocessor register read responder.
// Assumes phase and response codes are two bits wide on the CPU side.
package cpr_pkg;
    typedef enum logic [1:0] {
        PH_FIRST = 2'd0,
        PH_RETRY = 2'd1,
        PH_XFER  = 2'd2,
        PH_LAST  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_BUSY = 2'd1,
        RSP_DONE = 2'd2
    } rsp_e;
endpackage

// File: rtl/cpr_bank.sv
// Register bank: 2**IDX_W data registers with one load port and two
// combinational read ports. Assumes a single writer per cycle.
module cpr_bank #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int NREG = 1 << IDX_W;

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold one register; load it when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    // Present both read ports.
    always_comb begin
        rd_data_a = regs[rd_idx_a];
        rd_data_b = regs[rd_idx_b];
    end
endmodule

// File: rtl/cpr_timebase.sv
// Free-running cycle counter and deadline register. pending is high while
// the counter is below the deadline. Assumes the counter does not wrap
// within the lifetime of a deadline.
module cpr_timebase #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dl_we,
    input  logic [TS_W-1:0] dl_value,
    output logic [TS_W-1:0] now,
    output logic            pending
);
    logic [TS_W-1:0] now_q;
    logic [TS_W-1:0] deadline_q;

    // Advance the timebase every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + TS_W'(1);
    end

    // Capture the deadline left by an earlier operation.
    always_ff @(posedge clk) begin
        if (!rst_n)     deadline_q <= '0;
        else if (dl_we) deadline_q <= dl_value;
    end

    // Compare the current time with the deadline.
    always_comb begin
        now     = now_q;
        pending = now_q < deadline_q;
    end

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> now_q == $past(now_q) + TS_W'(1)); // R8
    AST_DEADLINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dl_we |=> deadline_q == $past(dl_value)); // R8
endmodule

// File: rtl/cpr_stall.sv
// Decides, for each request, between busy and completion. It keeps a
// down-counter of the remaining busy responses and an armed flag for a
// stall in progress. Assumes the wait count is stable during a stall.
module cpr_stall #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_phase,
    input  logic              dl_pending,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              finish,
    output logic              busy
);
    import cpr_pkg::*;

    logic [WAIT_W-1:0] cnt_q;
    logic              armed_q;
    logic              opener;
    logic              evaluate;
    logic              start;
    logic              load;

    // Classify the request and decide its outcome.
    always_comb begin
        opener   = (req_phase == PH_FIRST) || ((req_phase == PH_RETRY) && !armed_q);
        evaluate = req_valid && !dl_pending;
        start    = evaluate && opener;
        load     = start && (wait_cycles != '0);
        finish   = evaluate &&
                   ((start && (wait_cycles == '0)) ||
                    ((req_phase == PH_RETRY) && armed_q && (cnt_q == '0)));
        busy     = req_valid && !finish;
    end

    // Track the remaining stall length and whether a stall is armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= wait_cycles - WAIT_W'(1);
            armed_q <= 1'b1;
        end else if (finish) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - WAIT_W'(1);
        end
    end

    AST_ARMED_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> armed_q); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q != '0) && !load && !finish) |=> cnt_q == $past(cnt_q) - WAIT_W'(1)); // R4
    AST_NO_FINISH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        dl_pending |-> !finish); // R5
endmodule

// File: rtl/cpr_read_unit.sv
// Top of the coprocessor register read responder. It takes the register
// index from the instruction word, reads one or two bank registers and
// registers a none/busy/done response for the next cycle. Stalls come
// from the wait-count logic and from the timebase deadline.
module cpr_read_unit #(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 4,
    parameter int TS_W    = 32,
    parameter int WAIT_W  = 8,
    parameter int INSTR_W = 32,
    parameter int IDX_LSB = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bank_we,
    input  logic [IDX_W-1:0]   bank_waddr,
    input  logic [DATA_W-1:0]  bank_wdata,
    input  logic               dl_we,
    input  logic [TS_W-1:0]    dl_value,
    input  logic [WAIT_W-1:0]  wait_cycles,
    input  logic               req_valid,
    input  logic [1:0]         req_phase,
    input  logic               req_dual,
    input  logic [INSTR_W-1:0] req_instr,
    output logic [1:0]         rsp_code,
    output logic [DATA_W-1:0]  rsp_data0,
    output logic [DATA_W-1:0]  rsp_data1,
    output logic [TS_W-1:0]    cycle_now
);
    import cpr_pkg::*;

    localparam logic [INSTR_W-1:0] IDX_MASK = INSTR_W'((1 << IDX_W) - 1) << IDX_LSB;

    logic [IDX_W-1:0]  idx_a;
    logic [IDX_W-1:0]  idx_b;
    logic [DATA_W-1:0] val_a;
    logic [DATA_W-1:0] val_b;
    logic              dl_pending;
    logic              finish;
    logic              busy;
    logic              instr_unused;
    logic [1:0]        code_q;
    logic [DATA_W-1:0] d0_q;
    logic [DATA_W-1:0] d1_q;

    // Extract the source index and its wrapped successor.
    always_comb begin
        idx_a        = req_instr[IDX_LSB +: IDX_W];
        idx_b        = idx_a + IDX_W'(1);
        instr_unused = ^(req_instr & ~IDX_MASK);
    end

    cpr_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_we),
        .wr_idx    (bank_waddr),
        .wr_data   (bank_wdata),
        .rd_idx_a  (idx_a),
        .rd_idx_b  (idx_b),
        .rd_data_a (val_a),
        .rd_data_b (val_b)
    );

    cpr_timebase #(.TS_W(TS_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .dl_we    (dl_we),
        .dl_value (dl_value),
        .now      (cycle_now),
        .pending  (dl_pending)
    );

    cpr_stall #(.WAIT_W(WAIT_W)) u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_phase   (req_phase),
        .dl_pending  (dl_pending),
        .wait_cycles (wait_cycles),
        .finish      (finish),
        .busy        (busy)
    );

    // Register the response code and data for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= RSP_NONE;
            d0_q   <= '0;
            d1_q   <= '0;
        end else if (finish) begin
            code_q <= RSP_DONE;
            d0_q   <= val_a;
            d1_q   <= req_dual ? val_b : '0;
        end else begin
            code_q <= busy ? RSP_BUSY : RSP_NONE;
            d0_q   <= '0;
            d1_q   <= '0;
        end
    end

    // Drive the response ports.
    always_comb begin
        rsp_code  = code_q;
        rsp_data0 = d0_q;
        rsp_data1 = d1_q;
    end

    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> rsp_code == RSP_NONE); // R1
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_code != 2'd3); // R1
    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != RSP_DONE) |-> ((rsp_data0 == '0) && (rsp_data1 == '0))); // R2
    AST_OTHER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_phase[1]) |=> rsp_code == RSP_BUSY); // R7
    AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == RSP_DONE) |-> !$past(dl_pending)); // R5
endmodule

// File: tb/cpr_read_unit_tb.sv
module cpr_read_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_we = 1'b0;
    logic [3:0]  bank_waddr = '0;
    logic [31:0] bank_wdata = '0;
    logic        dl_we = 1'b0;
    logic [31:0] dl_value = '0;
    logic [7:0]  wait_cycles = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_phase = '0;
    logic        req_dual = 1'b0;
    logic [31:0] req_instr = '0;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_data0;
    logic [31:0] rsp_data1;
    logic [31:0] cycle_now;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cpr_read_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_waddr(bank_waddr),
        .bank_wdata(bank_wdata), .dl_we(dl_we), .dl_value(dl_value),
        .wait_cycles(wait_cycles), .req_valid(req_valid), .req_phase(req_phase),
        .req_dual(req_dual), .req_instr(req_instr), .rsp_code(rsp_code),
        .rsp_data0(rsp_data0), .rsp_data1(rsp_data1), .cycle_now(cycle_now)
    );

    function automatic logic [31:0] bval(input int i);
        return 32'hA500_0000 + 32'(i) * 32'h0101_0101;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request on a falling edge, read the response one edge later.
    task automatic issue(input logic [1:0] ph, input logic dual, input int idx);
        req_valid = 1'b1;
        req_phase = ph;
        req_dual  = dual;
        req_instr = {12'hABC, 4'(idx), 16'h5A5A};
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Retry until done; return the number of busy responses seen.
    task automatic run_until_done(input logic [1:0] first_ph, input logic [1:0] rest_ph,
                                  input int idx, output int nbusy);
        nbusy = 0;
        issue(first_ph, 1'b0, idx);
        for (int k = 0; k < 40 && rsp_code == 2'd1; k++) begin
            nbusy++;
            issue(rest_ph, 1'b0, idx);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nb;
        logic [31:0] t0;
        logic [31:0] c;
        repeat (3) @(negedge clk);
        chk("R9 code in reset", 32'(rsp_code), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 code after reset", 32'(rsp_code), 32'd0);
        chk("R9 data0 after reset", rsp_data0, 32'd0);
        chk("R9 data1 after reset", rsp_data1, 32'd0);
        t0 = cycle_now;
        chk("R8 counter starts near zero", 32'(t0 <= 32'd1), 32'd1);
        @(negedge clk);
        chk("R8 counter step", cycle_now, t0 + 32'd1);

        for (int i = 0; i < 16; i++) begin
            bank_we = 1'b1; bank_waddr = 4'(i); bank_wdata = bval(i);
            @(negedge clk);
        end
        bank_we = 1'b0;

        @(negedge clk);
        chk("R1 idle gives none", 32'(rsp_code), 32'd0);

        for (int i = 0; i < 16; i++) begin
            for (int d = 0; d < 2; d++) begin
                issue(2'd0, 1'(d), i);
                chk("R1 done code", 32'(rsp_code), 32'd2);
                chk("R2 data0", rsp_data0, bval(i));
                chk("R3 data1", rsp_data1, (d == 1) ? bval((i + 1) % 16) : 32'd0);
            end
        end
        @(negedge clk);
        chk("R1 none after idle", 32'(rsp_code), 32'd0);
        chk("R2 data zero when not done", rsp_data0, 32'd0);

        bank_we = 1'b1; bank_waddr = 4'd7; bank_wdata = 32'h1234_5678;
        @(negedge clk);
        bank_we = 1'b0;
        issue(2'd0, 1'b1, 6);
        chk("R10 reload seen on data1", rsp_data1, 32'h1234_5678);
        issue(2'd0, 1'b0, 7);
        chk("R10 reload seen on data0", rsp_data0, 32'h1234_5678);

        issue(2'd2, 1'b0, 3);
        chk("R7 phase 2 busy", 32'(rsp_code), 32'd1);
        issue(2'd3, 1'b0, 3);
        chk("R7 phase 3 busy", 32'(rsp_code), 32'd1);

        issue(2'd1, 1'b0, 4);
        chk("R6 lone retry completes", 32'(rsp_code), 32'd2);
        chk("R6 lone retry data", rsp_data0, bval(4));

        for (int n = 1; n <= 6; n++) begin
            wait_cycles = 8'(n);
            run_until_done(2'd0, 2'd1, n, nb);
            chk("R4 busy response count", 32'(nb), 32'(n));
            chk("R4 completion code", 32'(rsp_code), 32'd2);
            chk("R4 completion data", rsp_data0, bval(n));
        end

        wait_cycles = 8'd3;
        run_until_done(2'd1, 2'd1, 9, nb);
        chk("R6 retry opener arms stall", 32'(nb), 32'd3);
        chk("R6 retry opener data", rsp_data0, bval(9));
        wait_cycles = 8'd0;

        for (int dd = 1; dd <= 6; dd += 2) begin
            c = cycle_now;
            dl_we = 1'b1; dl_value = c + 32'd1 + 32'(dd);
            @(negedge clk);
            dl_we = 1'b0;
            run_until_done(2'd0, 2'd0, 11, nb);
            chk("R5 deadline busy count", 32'(nb), 32'(dd));
            chk("R5 deadline completion data", rsp_data0, bval(11));
        end

        wait_cycles = 8'd2;
        c = cycle_now;
        dl_we = 1'b1; dl_value = c + 32'd3;
        @(negedge clk);
        dl_we = 1'b0;
        run_until_done(2'd1, 2'd1, 12, nb);
        chk("R5 deadline then wait count", 32'(nb), 32'd4);
        chk("R5 combined completion", rsp_data0, bval(12));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule